// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block follows the power state of a single DRAM rank and moves it between idle, bank-open, refresh, self-refresh and two power-down states. The memory scheduler sends it single-cycle pulses when it opens a bank, closes all banks, issues a read burst or receives read data. It also raises requests for refresh, self-refresh, power-down and wake. The block reports the current state, marks the first cycle of each granted refresh and of each low-power entry, and keeps a sticky error flag.

A refresh that arrives while banks are open is held back until the scheduler closes every bank. The rank then passes through idle for exactly one cycle and goes straight into refresh, even if read data from the last bursts is still on its way. Low-power entry needs two things: no read data owed and no refresh pending or running. If the rank ever sits in a low-power state while read data arrives, the error flag is set.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle) and `err_o`, `ref_grant_o` and `lp_enter_o` are all 0. The state codes are: idle 0, active 1, refresh 2, self-refresh 3, precharge power-down 4, active power-down 5.
- R2: An activate pulse in idle moves the state to active on the next cycle. A precharge-all pulse in active moves it back to idle on the next cycle.
- R3: A refresh request that arrives in active does not change the state. After the next precharge-all the state is idle for one cycle, then refresh, and `ref_grant_o` is high only in the first refresh cycle.
- R4: Refresh lasts exactly `REF_CYC` cycles and then returns to idle with the pending request cleared.
- R5: Read data returning in idle, active or refresh leaves `err_o` low. Read data returning in self-refresh or in either power-down state sets `err_o` on the next cycle.
- R6: A power-down or self-refresh request is ignored (the state does not change) while read bursts are owed, or while a refresh is pending or running.
- R7: A power-down request that is accepted enters active power-down from active and precharge power-down from idle. `lp_enter_o` is high in the first cycle of the new state only.
- R8: A wake pulse returns precharge power-down to idle and active power-down to active. A self-refresh exit pulse returns self-refresh to idle.
- R9: An accepted self-refresh request in idle moves the state to self-refresh and pulses `lp_enter_o`.
- R10: If low-power entry is taken in a cycle that also carries an activate or precharge-all pulse, the entry still happens and `err_o` is set.
- R11: Once set, `err_o` stays high until reset.
- R12: In idle, a pending refresh is granted on the next cycle even when read bursts are still owed, and it takes priority over power-down and activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | Bank activate pulse |
| pre_all_i | input | 1 | Precharge-all pulse |
| rd_issue_i | input | 1 | Read burst issued pulse |
| rd_return_i | input | 1 | Read data returned pulse |
| ref_due_i | input | 1 | Refresh due pulse |
| sref_req_i | input | 1 | Self-refresh entry request |
| sref_exit_i | input | 1 | Self-refresh exit pulse |
| pd_req_i | input | 1 | Power-down entry request |
| wake_i | input | 1 | Power-down exit pulse |
| state_o | output | 3 | Current power state code |
| ref_grant_o | output | 1 | First cycle of a refresh |
| lp_enter_o | output | 1 | First cycle of a low-power state |
| err_o | output | 1 | Sticky protocol error |

## Verification
A wrong count of owed reads shows up within one cycle of a power-down request: the state either fails to leave idle or leaves it too early. A lost refresh-pending flag shows up as an idle state that never turns into refresh after the closing precharge. A refresh timer that is off by one shows up as a refresh of the wrong length, seen on the cycle the state returns to idle. A wrong legality test on read return shows up on `err_o` one cycle after the return pulse, and because the flag is sticky it stays visible until reset.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [2:0] {
        PS_IDLE = 3'd0,
        PS_ACT  = 3'd1,
        PS_REF  = 3'd2,
        PS_SREF = 3'd3,
        PS_PPD  = 3'd4,
        PS_APD  = 3'd5
    } pstate_t;

    typedef struct packed {
        pstate_t state;
        logic    ref_pend;
        logic    err;
        logic    lp_enter;
        logic    ref_grant;
    } ctrl_t;

    function automatic logic is_low_power(input pstate_t s);
        return (s == PS_SREF) || (s == PS_PPD) || (s == PS_APD);
    endfunction

endpackage

// File: rtl/rpc_evt_cnt.sv
module rpc_evt_cnt #(
    parameter int EVT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic zero_o
);
    localparam logic [EVT_W-1:0] CNT_MAX = {EVT_W{1'b1}};

    logic [EVT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && !dec_i && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end else if (dec_i && !inc_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rpc_ref_timer.sv
module rpc_ref_timer #(
    parameter int REF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int REF_W = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
    localparam logic [REF_W-1:0] LAST = REF_W'(REF_CYC - 1);

    logic [REF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl
    import rpc_pkg::*;
#(
    parameter int REF_CYC = 8,
    parameter int EVT_W   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_i,
    input  logic       pre_all_i,
    input  logic       rd_issue_i,
    input  logic       rd_return_i,
    input  logic       ref_due_i,
    input  logic       sref_req_i,
    input  logic       sref_exit_i,
    input  logic       pd_req_i,
    input  logic       wake_i,
    output logic [2:0] state_o,
    output logic       ref_grant_o,
    output logic       lp_enter_o,
    output logic       err_o
);
    ctrl_t cur_q, nxt_d;
    logic  evt_zero;
    logic  ref_done;
    logic  pend;
    logic  lp_ok;

    rpc_evt_cnt #(.EVT_W(EVT_W)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (rd_issue_i),
        .dec_i  (rd_return_i),
        .zero_o (evt_zero)
    );

    rpc_ref_timer #(.REF_CYC(REF_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (cur_q.state == PS_REF),
        .done_o (ref_done)
    );

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.lp_enter  = 1'b0;
        nxt_d.ref_grant = 1'b0;
        pend            = cur_q.ref_pend | ref_due_i;
        lp_ok           = evt_zero && !pend && (cur_q.state != PS_REF);
        nxt_d.ref_pend  = pend;

        case (cur_q.state)
            PS_IDLE: begin
                if (pend) begin
                    nxt_d.state     = PS_REF;
                    nxt_d.ref_grant = 1'b1;
                end else if (sref_req_i && lp_ok) begin
                    nxt_d.state    = PS_SREF;
                    nxt_d.lp_enter = 1'b1;
                end else if (pd_req_i && lp_ok) begin
                    nxt_d.state    = PS_PPD;
                    nxt_d.lp_enter = 1'b1;
                end else if (act_i) begin
                    nxt_d.state = PS_ACT;
                end
            end
            PS_ACT: begin
                if (pre_all_i) begin
                    nxt_d.state = PS_IDLE;
                end else if (pd_req_i && lp_ok) begin
                    nxt_d.state    = PS_APD;
                    nxt_d.lp_enter = 1'b1;
                end
            end
            PS_REF: begin
                if (ref_done) begin
                    nxt_d.state    = PS_IDLE;
                    nxt_d.ref_pend = ref_due_i;
                end
            end
            PS_SREF: if (sref_exit_i) nxt_d.state = PS_IDLE;
            PS_PPD:  if (wake_i)      nxt_d.state = PS_IDLE;
            PS_APD:  if (wake_i)      nxt_d.state = PS_ACT;
            default: nxt_d.state = PS_IDLE;
        endcase

        if (nxt_d.lp_enter && (act_i || pre_all_i)) nxt_d.err = 1'b1;
        if (rd_return_i && is_low_power(cur_q.state)) nxt_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: PS_IDLE, ref_pend: 1'b0, err: 1'b0,
                       lp_enter: 1'b0, ref_grant: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o     = cur_q.state;
    assign ref_grant_o = cur_q.ref_grant;
    assign lp_enter_o  = cur_q.lp_enter;
    assign err_o       = cur_q.err;

endmodule

// File: rtl/rpc_chk.sv
module rpc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_return_i,
    input logic [2:0] state_o,
    input logic       ref_grant_o,
    input logic       lp_enter_o,
    input logic       err_o
);
    logic lp_now;
    assign lp_now = (state_o == 3'd3) || (state_o == 3'd4) || (state_o == 3'd5);

    AST_GRANT_ON_REF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && $past(state_o) != 3'd2) |-> ref_grant_o); // R3

    AST_REF_EXITS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 3'd2 && state_o != 3'd2) |-> state_o == 3'd0); // R4

    AST_RD_IN_LP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_return_i && lp_now) |=> err_o); // R5

    AST_APD_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5 && $past(state_o) != 3'd5) |-> $past(state_o) == 3'd1); // R7

    AST_LP_PULSE_IN_LP: assert property (@(posedge clk) disable iff (!rst_n)
        lp_enter_o |-> lp_now); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_o) |-> err_o); // R11

endmodule

bind rank_pwr_ctrl rpc_chk u_chk (.*);

// File: tb/tb_rank_pwr_ctrl.sv
module tb_rank_pwr_ctrl;
    localparam int RC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_i = 0, pre_all_i = 0, rd_issue_i = 0, rd_return_i = 0;
    logic ref_due_i = 0, sref_req_i = 0, sref_exit_i = 0, pd_req_i = 0, wake_i = 0;
    logic [2:0] state_o;
    logic ref_grant_o, lp_enter_o, err_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rank_pwr_ctrl #(.REF_CYC(RC), .EVT_W(3)) dut (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic reads(input int n, input bit ret);
        for (int i = 0; i < n; i++) begin
            if (ret) rd_return_i = 1; else rd_issue_i = 1;
            tick();
            rd_return_i = 0; rd_issue_i = 0;
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 state", state_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 grant", ref_grant_o, 0);
        chk("R1 lp", lp_enter_o, 0);

        act_i = 1; tick(); act_i = 0;
        chk("R2 act", state_o, 1);
        pre_all_i = 1; tick(); pre_all_i = 0;
        chk("R2 pre", state_o, 0);

        // refresh arriving around reads
        act_i = 1; tick(); act_i = 0;
        reads(2, 0);
        ref_due_i = 1; tick(); ref_due_i = 0;
        tick(); tick();
        chk("R3 held in act", state_o, 1);
        pre_all_i = 1; tick(); pre_all_i = 0;
        chk("R3 idle after pre", state_o, 0);
        tick();
        chk("R12 ref with reads owed", state_o, 2);
        chk("R3 grant first", ref_grant_o, 1);
        for (int k = 1; k < RC; k++) begin
            rd_return_i = (k <= 2);
            tick();
            rd_return_i = 0;
            chk("R4 still ref", state_o, 2);
            chk("R3 grant low", ref_grant_o, 0);
        end
        tick();
        chk("R4 back idle", state_o, 0);
        chk("R5 no err on return in ref", err_o, 0);
        tick();
        chk("R4 pend cleared", state_o, 0);

        // sweep owed reads against power-down gating
        for (int n = 0; n < 4; n++) begin
            reads(n, 0);
            pd_req_i = 1; tick(); pd_req_i = 0;
            chk("R6 pd gated by reads", state_o, (n == 0) ? 4 : 0);
            if (n != 0) begin
                reads(n, 1);
                chk("R5 return in idle", err_o, 0);
                pd_req_i = 1; tick(); pd_req_i = 0;
                chk("R7 ppd from idle", state_o, 4);
            end
            chk("R7 lp pulse", lp_enter_o, 1);
            tick();
            chk("R7 lp pulse one cycle", lp_enter_o, 0);
            wake_i = 1; tick(); wake_i = 0;
            chk("R8 ppd wake", state_o, 0);
        end

        // refresh blocks low-power entry and wins priority
        ref_due_i = 1; pd_req_i = 1; act_i = 1; tick();
        ref_due_i = 0; pd_req_i = 0; act_i = 0;
        chk("R12 ref priority", state_o, 2);
        sref_req_i = 1; pd_req_i = 1; tick(); sref_req_i = 0; pd_req_i = 0;
        chk("R6 no lp in ref", state_o, 2);
        for (int k = 2; k < RC; k++) tick();
        tick();
        chk("R4 ref length", state_o, 0);

        // active power-down
        act_i = 1; tick(); act_i = 0;
        pd_req_i = 1; tick(); pd_req_i = 0;
        chk("R7 apd from act", state_o, 5);
        wake_i = 1; tick(); wake_i = 0;
        chk("R8 apd wake", state_o, 1);
        ref_due_i = 1; tick(); ref_due_i = 0;
        pd_req_i = 1; tick(); pd_req_i = 0;
        chk("R6 pd blocked by pending ref", state_o, 1);
        pre_all_i = 1; tick(); pre_all_i = 0;
        for (int k = 0; k < RC + 1; k++) tick();
        chk("R4 idle after pending ref", state_o, 0);

        // self-refresh and read return in each low-power state
        for (int s = 0; s < 3; s++) begin
            do_reset();
            if (s == 0) begin
                sref_req_i = 1; tick(); sref_req_i = 0;
                chk("R9 sref", state_o, 3);
                chk("R9 lp pulse", lp_enter_o, 1);
            end else if (s == 1) begin
                pd_req_i = 1; tick(); pd_req_i = 0;
            end else begin
                act_i = 1; tick(); act_i = 0;
                pd_req_i = 1; tick(); pd_req_i = 0;
            end
            chk("R5 pre err", err_o, 0);
            rd_return_i = 1; tick(); rd_return_i = 0;
            chk("R5 err on return in lp", err_o, 1);
            sref_exit_i = 1; wake_i = 1; tick(); sref_exit_i = 0; wake_i = 0;
            chk("R8 exit", state_o, (s == 2) ? 1 : 0);
            tick();
            chk("R11 sticky", err_o, 1);
        end

        // entry with a concurrent activate
        do_reset();
        chk("R11 cleared by reset", err_o, 0);
        act_i = 1; tick(); act_i = 0;
        pd_req_i = 1; act_i = 1; tick(); pd_req_i = 0; act_i = 0;
        chk("R10 entry taken", state_o, 5);
        chk("R10 err", err_o, 1);
        do_reset();
        pd_req_i = 1; pre_all_i = 1; tick(); pd_req_i = 0; pre_all_i = 0;
        chk("R10 entry taken idle", state_o, 4);
        chk("R10 err pre", err_o, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule